// File: doc/BRIEF.md
# Banked Debug Comparator Register File

This block holds the register banks of three address comparator channels (A, B and C) for an on-chip debug unit. It also holds a sticky per-channel match-flag register. Software reaches the banks through a byte-wide register bus. A 2-bit bank selector decides which channel's bank appears in a shared eight-byte window, so the three channels never need separate address space, even though their register sets differ in size.

During a debug session, each channel watches a bus-monitor port. The port carries a valid strobe, a 24-bit address and 16-bit data. When an enabled channel matches, the block records it in that channel's flag. The flag then stays set until the next arm pulse from the debug controller, so it can still be read after the session ends. Channel A can also require a masked data match. Channels B and C compare address only.

Top module: `dbgcmp_regfile`

## Requirements
- R1: After a synchronous active-low reset, every readable byte at every selector value and local address reads 0x00, and all match flags are clear.
- R2: Selector values 0, 1 and 2 map the window (local addresses 8 to 15) to channels A, B and C. With selector 3, window reads return 0x00 and window writes change no channel register.
- R3: The window byte order is fixed by local address: 8 control, 9 address [23:16], 10 address [15:8], 11 address [7:0], 12 data [15:8], 13 data [7:0], 14 mask [15:8], 15 mask [7:0]. Local addresses 0 to 6 always read 0x00.
- R4: Channel A implements all eight window bytes as read/write registers holding the last value written.
- R5: Channels B and C implement only the control byte and the three address bytes. Their bytes at addresses 12 to 15 read 0x00, and writes to those bytes are ignored.
- R6: The control bytes of channels A and C store all eight bits. Channel B's control byte stores only bits [3:0], and bits [7:4] read 0.
- R7: The match-flag byte is at local address 7, with channel A in bit 0, B in bit 1 and C in bit 2, and bits [7:3] zero. It reads back only when the selector is 3; otherwise address 7 reads 0x00. Writes to address 7 are ignored.
- R8: A channel matches when the bus valid strobe is high, its control bit 0 is 1, and the bus address equals its three address bytes. A match while session-active is high sets that channel's flag at the next clock edge.
- R9: When channel A's control bit 1 is 1, channel A also needs (bus_data XOR data bytes) AND mask bytes to equal zero. A mask bit of 1 means that data bit is compared. Control bit 1 has no match effect on B or C.
- R10: A set flag stays set through further matches and non-matches until an arm pulse. The flags are independent, so one set flag never blocks another.
- R11: An arm pulse clears all flags at the next clock edge, even when a match occurs in the same cycle.
- R12: While session-active is low, matches leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | Bank selector for the window; 3 exposes the flag byte |
| reg_addr | input | 4 | Local byte address on the register bus |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address and selector |
| arm_pulse | input | 1 | One-cycle arm request from the debug controller; starts a new session |
| session_active | input | 1 | High while a debug session is running |
| bus_valid | input | 1 | Bus-monitor cycle valid |
| bus_addr | input | 24 | Bus-monitor address |
| bus_data | input | 16 | Bus-monitor data |

## Verification
The in-line assertions check the flag rules on every cycle: arm clears the flags, a set flag stays set, nothing changes outside a session, and a flag can only rise when its channel's hit is present. They also check that address 7 is hidden unless the selector is 3, and that selector 3 makes the window read as empty. Only the bench's scenarios can show that the window layout is correct for each channel. The same holds for channel B's narrow control byte, for unimplemented bytes ignoring writes, and for whether the masked data compare and 24-bit address compare pick the right bits. To cover these, the bench keeps a byte-level model of every bank. It then compares that model against readback after directed and random write and bus traffic.

// File: rtl/dbgcmp_pkg.sv
// Package: shared constants and window slot encoding for the banked debug
// comparator register file. Assumes byte-wide register access.
package dbgcmp_pkg;
    localparam int NUM_CH     = 3;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 2;
    localparam int LADDR_W    = 4;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;

    // Local address of the match-flag byte (just below the window)
    localparam logic [LADDR_W-1:0] FLAG_LADDR = 4'd7;
    // Selector value that exposes the flag byte
    localparam logic [SEL_W-1:0]   FLAG_SEL   = 2'd3;

    // Control bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DCE_BIT = 1;

    // Byte slots inside the shared window, in behavioural order
    typedef enum logic [2:0] {
        SLOT_CTRL   = 3'd0,
        SLOT_ADDR_H = 3'd1,
        SLOT_ADDR_M = 3'd2,
        SLOT_ADDR_L = 3'd3,
        SLOT_DATA_H = 3'd4,
        SLOT_DATA_L = 3'd5,
        SLOT_MASK_H = 3'd6,
        SLOT_MASK_L = 3'd7
    } win_slot_e;
endpackage

// File: rtl/dbgcmp_channel.sv
// Module: one comparator channel. Holds the control byte, the three address
// bytes and, when HAS_DATA is set, the data and mask bytes. Produces a
// combinational hit from the bus-monitor inputs.
// Assumes: wr_en is already qualified by bank selection and window decode.
module dbgcmp_channel
    import dbgcmp_pkg::*;
#(
    parameter bit               HAS_DATA  = 1'b1,
    parameter logic [BYTE_W-1:0] CTRL_MASK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        slot,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              hit
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] addr_h_q, addr_m_q, addr_l_q;
    logic [BYTE_W-1:0] data_h_q, data_l_q, mask_h_q, mask_l_q;
    logic              addr_eq;
    logic              data_ok;
    win_slot_e         slot_e;

    assign slot_e = win_slot_e'(slot);

    // Control and address byte storage, present in every channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            addr_h_q <= '0;
            addr_m_q <= '0;
            addr_l_q <= '0;
        end else if (wr_en) begin
            case (slot_e)
                SLOT_CTRL:   ctrl_q   <= wdata & CTRL_MASK;
                SLOT_ADDR_H: addr_h_q <= wdata;
                SLOT_ADDR_M: addr_m_q <= wdata;
                SLOT_ADDR_L: addr_l_q <= wdata;
                default:     ;
            endcase
        end
    end

    generate
        if (HAS_DATA) begin : g_data
            // Data and mask byte storage, data-capable channel only
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_h_q <= '0;
                    data_l_q <= '0;
                    mask_h_q <= '0;
                    mask_l_q <= '0;
                end else if (wr_en) begin
                    case (slot_e)
                        SLOT_DATA_H: data_h_q <= wdata;
                        SLOT_DATA_L: data_l_q <= wdata;
                        SLOT_MASK_H: mask_h_q <= wdata;
                        SLOT_MASK_L: mask_l_q <= wdata;
                        default:     ;
                    endcase
                end
            end

            // Masked data compare gated by the data-compare control bit
            always_comb begin
                data_ok = 1'b1;
                if (ctrl_q[CTRL_DCE_BIT]) begin
                    data_ok = (((bus_data ^ {data_h_q, data_l_q})
                              & {mask_h_q, mask_l_q}) == '0);
                end
            end
        end else begin : g_nodata
            logic unused_bus_data;
            assign unused_bus_data = ^bus_data;
            assign data_h_q = '0;
            assign data_l_q = '0;
            assign mask_h_q = '0;
            assign mask_l_q = '0;
            assign data_ok  = 1'b1;
        end
    endgenerate

    // Full-width address equality against the stored address bytes
    assign addr_eq = (bus_addr == {addr_h_q, addr_m_q, addr_l_q});

    // Qualified hit: valid cycle, channel enabled, address and data agree
    assign hit = bus_valid & ctrl_q[CTRL_EN_BIT] & addr_eq & data_ok;

    // Readback multiplexer over the window slots
    always_comb begin
        case (slot_e)
            SLOT_CTRL:   rdata = ctrl_q;
            SLOT_ADDR_H: rdata = addr_h_q;
            SLOT_ADDR_M: rdata = addr_m_q;
            SLOT_ADDR_L: rdata = addr_l_q;
            SLOT_DATA_H: rdata = data_h_q;
            SLOT_DATA_L: rdata = data_l_q;
            SLOT_MASK_H: rdata = mask_h_q;
            default:     rdata = mask_l_q;
        endcase
    end

    // Storage may only move on a qualified write
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q)); // R4
    AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && slot == 3'd0 |=> (ctrl_q & ~CTRL_MASK) == '0); // R6
endmodule

// File: rtl/dbgcmp_flags.sv
// Module: sticky per-channel match flags. A flag sets on a hit while the
// session is active and clears only on an arm pulse, which wins over a
// same-cycle hit. Assumes hits are already qualified per channel.
module dbgcmp_flags
    import dbgcmp_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_pulse,
    input  logic         session_active,
    input  logic [N-1:0] hit,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // One sticky bit per channel: arm clears, session hit sets
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else if (arm_pulse)
                    flags[i] <= 1'b0;
                else if (session_active && hit[i])
                    flags[i] <= 1'b1;
            end

            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                flags[i] && !arm_pulse |=> flags[i]); // R10
            AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                !flags[i] && !(hit[i] && session_active) |=> !flags[i]); // R8
        end
    endgenerate

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pulse |=> flags == '0); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !session_active && !arm_pulse |=> $stable(flags)); // R12
endmodule

// File: rtl/dbgcmp_regfile.sv
// Module: top of the banked debug comparator register file. Decodes the
// register bus into a shared window selected by bank_sel, instantiates the
// three channels (A with data compare, B with a narrow control byte) and the
// sticky flag register. Assumes one register access per cycle.
module dbgcmp_regfile
    import dbgcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   bank_sel,
    input  logic [LADDR_W-1:0] reg_addr,
    input  logic               reg_wr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    input  logic               arm_pulse,
    input  logic               session_active,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data
);
    localparam int PAD_W = BYTE_W - NUM_CH;

    logic              in_window;
    logic [2:0]        slot;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] flags;

    // Window decode: upper half of the local space is the shared window
    assign in_window = reg_addr[LADDR_W-1];
    assign slot      = reg_addr[2:0];

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam bit               HAS_D = (i == 0);
            localparam logic [BYTE_W-1:0] CMASK = (i == 1) ? 8'h0F : 8'hFF;
            logic wr_sel;
            assign wr_sel = reg_wr && in_window && (bank_sel == SEL_W'(i));

            dbgcmp_channel #(
                .HAS_DATA  (HAS_D),
                .CTRL_MASK (CMASK)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_sel),
                .slot      (slot),
                .wdata     (reg_wdata),
                .rdata     (ch_rdata[i]),
                .bus_valid (bus_valid),
                .bus_addr  (bus_addr),
                .bus_data  (bus_data),
                .hit       (ch_hit[i])
            );
        end
    endgenerate

    dbgcmp_flags #(.N(NUM_CH)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_pulse      (arm_pulse),
        .session_active (session_active),
        .hit            (ch_hit),
        .flags          (flags)
    );

    // Read path: selected bank in the window, flag byte only under FLAG_SEL
    always_comb begin
        reg_rdata = '0;
        if (in_window) begin
            if (bank_sel != FLAG_SEL)
                reg_rdata = ch_rdata[bank_sel];
        end else if (reg_addr == FLAG_LADDR && bank_sel == FLAG_SEL) begin
            reg_rdata = {{PAD_W{1'b0}}, flags};
        end
    end

    AST_FLAG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == FLAG_LADDR && bank_sel != FLAG_SEL |-> reg_rdata == '0); // R7
    AST_SEL3_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_window && bank_sel == FLAG_SEL |-> reg_rdata == '0); // R2
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window && reg_addr != FLAG_LADDR |-> reg_rdata == '0); // R3
    AST_FLAG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BYTE_W-1:NUM_CH] == '0 || in_window); // R7
endmodule

// File: tb/dbgcmp_regfile_bench.sv
module dbgcmp_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        arm_pulse = 1'b0;
    logic        session_active = 1'b0;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_reg [3][8];
    logic [2:0] m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgcmp_regfile u_dbgcmp_regfile (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arm_pulse(arm_pulse), .session_active(session_active),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] s, input logic [3:0] a);
        if (a[3]) return (s == 2'd3) ? 8'h00 : m_reg[s][a[2:0]];
        if (a == 4'd7 && s == 2'd3) return {5'b0, m_flag};
        return 8'h00;
    endfunction

    function automatic bit exp_hit(input int ch, input logic v,
                                   input logic [23:0] a, input logic [15:0] d);
        logic [15:0] dv, mv;
        dv = {m_reg[ch][4], m_reg[ch][5]};
        mv = {m_reg[ch][6], m_reg[ch][7]};
        if (!v || !m_reg[ch][0][0]) return 1'b0;
        if (a != {m_reg[ch][1], m_reg[ch][2], m_reg[ch][3]}) return 1'b0;
        if (ch == 0 && m_reg[ch][0][1] && (((d ^ dv) & mv) != 16'h0)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bank_sel = s; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        if (a[3] && s != 2'd3 && (s == 2'd0 || a[2:0] < 3'd4))
            m_reg[s][a[2:0]] = (s == 2'd1 && a[2:0] == 3'd0) ? (d & 8'h0F) : d;
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] s, input logic [3:0] a);
        @(negedge clk);
        bank_sel = s; reg_addr = a;
        #1 check(req, reg_rdata, exp_read(s, a));
    endtask

    task automatic cyc(input logic v, input logic [23:0] a, input logic [15:0] d,
                       input logic sess, input logic arm);
        logic [2:0] h;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d; session_active = sess; arm_pulse = arm;
        for (int c = 0; c < 3; c++) h[c] = exp_hit(c, v, a, d);
        @(posedge clk);
        if (arm) m_flag = 3'b000;
        else if (sess) m_flag = m_flag | h;
        #1 begin bus_valid = 1'b0; arm_pulse = 1'b0; end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [23:0] ra;
        logic [15:0] rdv;
        int ch;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) for (int k = 0; k < 8; k++) m_reg[c][k] = 8'h00;
        m_flag = 3'b000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 16; a++) rd("R1 reset", 2'(s), 4'(a));

        // R3 R4: channel A byte order and full storage
        for (int k = 0; k < 8; k++) wr(2'd0, 4'(8 + k), 8'(8'h11 * (k + 1)));
        for (int k = 0; k < 8; k++) rd("R4 chanA bytes", 2'd0, 4'(8 + k));
        rd("R3 low space", 2'd0, 4'd2);
        // R5 R6: channel B narrow control and missing data bytes
        for (int k = 0; k < 8; k++) wr(2'd1, 4'(8 + k), 8'hFF);
        rd("R6 chanB ctrl", 2'd1, 4'd8);
        for (int k = 1; k < 8; k++) rd("R5 chanB bytes", 2'd1, 4'(8 + k));
        for (int k = 0; k < 8; k++) wr(2'd2, 4'(8 + k), 8'hF0 | 8'(k));
        rd("R6 chanC ctrl", 2'd2, 4'd8);
        for (int k = 4; k < 8; k++) rd("R5 chanC bytes", 2'd2, 4'(8 + k));
        // R2: selector 3 window is empty and ignores writes
        wr(2'd3, 4'd9, 8'hA5);
        rd("R2 sel3 window", 2'd3, 4'd9);
        for (int s = 0; s < 3; s++) rd("R2 banks intact", 2'(s), 4'd9);
        // R7: flag byte ignores writes
        wr(2'd3, 4'd7, 8'hFF);
        rd("R7 flag write ignored", 2'd3, 4'd7);

        // R8: address match on A during session
        wr(2'd0, 4'd8, 8'h01);
        wr(2'd0, 4'd9, 8'h12); wr(2'd0, 4'd10, 8'h34); wr(2'd0, 4'd11, 8'h56);
        cyc(1'b1, 24'h123456, 16'h0, 1'b1, 1'b1);
        cyc(1'b1, 24'h123457, 16'h0, 1'b1, 1'b0);
        rd("R8 near miss", 2'd3, 4'd7);
        cyc(1'b1, 24'h123456, 16'h0, 1'b1, 1'b0);
        rd("R8 flag A", 2'd3, 4'd7);
        rd("R7 hidden sel0", 2'd0, 4'd7);
        // R12: B match outside session does nothing
        wr(2'd1, 4'd8, 8'h01);
        wr(2'd1, 4'd9, 8'hAB); wr(2'd1, 4'd10, 8'hCD); wr(2'd1, 4'd11, 8'hEF);
        cyc(1'b1, 24'hABCDEF, 16'h0, 1'b0, 1'b0);
        rd("R12 no session", 2'd3, 4'd7);
        // R10: sticky A and independent B
        cyc(1'b1, 24'hABCDEF, 16'h0, 1'b1, 1'b0);
        cyc(1'b1, 24'h000000, 16'h0, 1'b1, 1'b0);
        rd("R10 sticky and independent", 2'd3, 4'd7);
        // R11: arm with same-cycle match leaves flags clear
        cyc(1'b1, 24'hABCDEF, 16'h0, 1'b1, 1'b1);
        rd("R11 arm wins", 2'd3, 4'd7);
        // R9: masked data compare on A
        wr(2'd0, 4'd8, 8'h03);
        wr(2'd0, 4'd12, 8'hAB); wr(2'd0, 4'd13, 8'h00);
        wr(2'd0, 4'd14, 8'hFF); wr(2'd0, 4'd15, 8'h00);
        cyc(1'b1, 24'h123456, 16'hAC77, 1'b1, 1'b0);
        rd("R9 data mismatch", 2'd3, 4'd7);
        cyc(1'b1, 24'h123456, 16'hAB77, 1'b1, 1'b0);
        rd("R9 masked match", 2'd3, 4'd7);
        // R9: control bit 1 has no effect on C
        wr(2'd2, 4'd8, 8'h03);
        wr(2'd2, 4'd9, 8'h00); wr(2'd2, 4'd10, 8'h00); wr(2'd2, 4'd11, 8'h42);
        cyc(1'b1, 24'h000042, 16'h1234, 1'b1, 1'b0);
        rd("R9 chanC no data", 2'd3, 4'd7);

        // Random mix of writes, reads, bus cycles and arms
        for (int it = 0; it < 1500; it++) begin
            case ($urandom_range(0, 9))
                0, 1: wr(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                         8'($urandom) | 8'($urandom_range(0, 1)));
                2: rd("R2 R3 R5 random read", 2'($urandom_range(0, 3)),
                      4'($urandom_range(0, 15)));
                3: cyc(1'b1, 24'h0, 16'h0, 1'b1, 1'b1);
                default: begin
                    ch = $urandom_range(0, 2);
                    ra = ($urandom_range(0, 3) != 0)
                         ? {m_reg[ch][1], m_reg[ch][2], m_reg[ch][3]} : 24'($urandom);
                    rdv = ($urandom_range(0, 1) != 0)
                          ? ({m_reg[0][4], m_reg[0][5]} ^ 16'($urandom_range(0, 3)))
                          : 16'($urandom);
                    cyc(1'($urandom_range(0, 5) != 0), ra, rdv,
                        1'($urandom_range(0, 3) != 0), 1'b0);
                    rd("R8 R9 R10 R12 random flags", 2'd3, 4'd7);
                end
            endcase
        end
        report();
    end
endmodule